// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order processor core split into five single-cycle stages: fetch, decode, execute, memory access and register writeback. It runs a compact load/store instruction set: three-register ALU operations (add, subtract, AND, OR, signed set-less-than), word load, word store, equal and not-equal conditional branches, and an absolute jump. Instruction and data storage are small word-addressed arrays inside the core. While the core is held in reset, a preload port fills them.

Data hazards are resolved without software help. Results still in flight are forwarded from the later pipeline registers. The register file passes a value being written straight through to a read of the same register in the same cycle. A load followed immediately by a consumer of its result costs exactly one bubble. Control transfers are never cancelled. A taken conditional branch redirects fetch from the memory stage, so the three instructions after it always run. A jump redirects from execute, so the two instructions after it always run. Software must fill those slots with useful work and must not place a branch or jump in them.

The architectural effects are visible at two output groups. One reports each register write as it happens in writeback. The other reports each store as it happens in the memory stage.

Top module: `pipe5_core`

## Requirements
- R1: Reset clears all pipeline state and the register file and sets the PC to 0. While reset is held, no register write or store is reported. After reset is released, the first instruction reports its register write in the output sample taken after the fourth rising clock edge.
- R2: For an instruction with opcode 0, the operation is chosen by bits [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). The result is written to the register named in bits [15:11]. Any other function code, or a nonzero bits [10:6], writes nothing.
- R3: A word load (opcode 0x23) writes to the register in bits [20:16] the data word at index (rs + sign-extended bits [15:0]) >> 2. The data array holds words written through the preload port while reset is low (ld_dmem=1 selects data, 0 selects instructions; ld_addr is the word index).
- R4: A word store (opcode 0x2B) writes the rt register value to the same kind of address. It is reported on st_en/st_addr/st_data in its memory stage, and later loads of that word return it.
- R5: An operand produced by one of the two preceding instructions is taken from the pipeline. When both of them write the register, the nearer (younger) one wins.
- R6: A load immediately followed by an instruction that reads its destination stalls fetch and decode for exactly one cycle. The consumer then sees the loaded value.
- R7: Register 0 always reads as zero. An instruction targeting it reports no register write and is never forwarded.
- R8: beq (opcode 0x04) and bne (opcode 0x05) compare rs with rt. When taken, the next PC is PC+4 + (sign-extended bits [15:0] << 2), and exactly the three instructions that follow the branch still execute.
- R9: A jump (opcode 0x02) loads the PC with the upper 4 bits of PC+4 concatenated with bits [25:0] << 2. Exactly the two instructions after it still execute.
- R10: A register written in writeback in the same cycle that a later instruction reads it in decode yields the new value (three-instruction distance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 data array, 0 instruction array |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| rf_we | output | 1 | A register write happens this cycle |
| rf_waddr | output | 5 | Register being written |
| rf_wdata | output | 32 | Value being written |
| st_en | output | 1 | A store happens this cycle |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |

## Verification
Directed programs each target one mechanism. The first covers every ALU function with operand signs that make set-less-than differ by order. The second covers back-to-back and two-apart dependencies, including a double write where only the younger value is right. Other programs cover load-use pairs, register-file pass-through at distance three, writes to register 0, and taken and not-taken beq and bne. The last directed program has a jump whose slots contain a load-use pair. Each case separates correct forwarding or slot counting from an off-by-one-cycle variant. Seeded random programs then mix all instruction kinds over a small register set, so that hazards of every distance overlap with stores and forward control transfers. The register-write and store streams are compared in order with a bench-side sequential model that has delay-slot semantics.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam logic [5:0] OPC_ALU   = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_BNE   = 6'h05;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        AM_ADD = 2'd0,
        AM_SUB = 2'd1,
        AM_FN  = 2'd2
    } alu_mode_e;

    typedef struct packed {
        logic      alu_src;
        alu_mode_e alu_mode;
        logic      reg_dst;
        logic      jump;
        logic      branch;
        logic      bne;
        logic      mem_rd;
        logic      mem_wr;
        logic      mem2reg;
        logic      reg_wr;
    } ctl_t;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc4;
    } ifid_t;

    typedef struct packed {
        ctl_t        ctl;
        logic [31:0] pc4;
        logic [31:0] rs_val;
        logic [31:0] rt_val;
        logic [31:0] imm;
        logic [31:0] jtgt;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [5:0]  funct;
    } idex_t;

    typedef struct packed {
        logic        branch;
        logic        bne;
        logic        mem_rd;
        logic        mem_wr;
        logic        mem2reg;
        logic        reg_wr;
        logic [31:0] bta;
        logic        zero;
        logic [31:0] alu;
        logic [31:0] rt_val;
        logic [4:0]  dst;
    } exmem_t;

    typedef struct packed {
        logic        mem2reg;
        logic        reg_wr;
        logic [31:0] rdata;
        logic [31:0] alu;
        logic [4:0]  dst;
    } memwb_t;

    typedef struct packed {
        logic [31:0] pc;
        logic        pend_v;
        logic [31:0] pend_t;
        ifid_t       ifid;
        idex_t       idex;
        exmem_t      exmem;
        memwb_t      memwb;
    } core_st_t;

    function automatic logic fn_legal(input logic [5:0] f);
        return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
               (f == FN_OR)  || (f == FN_SLT);
    endfunction

endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we && waddr != '0) begin
            regs_q[waddr] <= wdata;
        end
    end

    function automatic logic [W-1:0] rd_port(input logic [AW-1:0] a);
        if (a == '0)                return '0;
        if (we && waddr == a)       return wdata;
        return regs_q[a];
    endfunction

    always_comb begin
        rd1 = rd_port(ra1);
        rd2 = rd_port(ra2);
    end

    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1 == '0) |-> (rd1 == '0)); // R7
    AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
        (ra2 == '0) |-> (rd2 == '0)); // R7
    AST_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0 && ra1 == waddr) |-> (rd1 == wdata)); // R10
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu import pipe5_pkg::*; #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_mode_e    mode,
    input  logic [5:0]   funct,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        y = '0;
        unique case (mode)
            AM_ADD: y = a + b;
            AM_SUB: y = a - b;
            default: begin
                case (funct)
                    FN_ADD:  y = a + b;
                    FN_SUB:  y = a - b;
                    FN_AND:  y = a & b;
                    FN_OR:   y = a | b;
                    FN_SLT:  y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
                    default: y = '0;
                endcase
            end
        endcase
        zero = (y == '0);
    end

    always_comb begin
        AST_SLT_BOOLEAN: assert (!(mode == AM_FN && funct == FN_SLT) || y[W-1:1] == '0); // R2
    end
endmodule

// File: rtl/pipe5_fwd.sv
module pipe5_fwd #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   src,
    input  logic [W-1:0] rf_val,
    input  logic         ex_we,
    input  logic [4:0]   ex_dst,
    input  logic [W-1:0] ex_val,
    input  logic         wb_we,
    input  logic [4:0]   wb_dst,
    input  logic [W-1:0] wb_val,
    output logic [W-1:0] val
);
    logic ex_hit, wb_hit;

    always_comb begin
        ex_hit = ex_we && (ex_dst != 5'd0) && (ex_dst == src);
        wb_hit = wb_we && (wb_dst != 5'd0) && (wb_dst == src);
        if (ex_hit)      val = ex_val;
        else if (wb_hit) val = wb_val;
        else             val = rf_val;
    end

    AST_FWD_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_we && ex_dst == src && src != 5'd0) |-> (val == ex_val)); // R5
    AST_FWD_NONE_R0: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 5'd0) |-> (val == '0)); // R7
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core import pipe5_pkg::*; #(
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 6,
    localparam int LD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_dmem,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [31:0]      ld_data,
    output logic             rf_we,
    output logic [4:0]       rf_waddr,
    output logic [31:0]      rf_wdata,
    output logic             st_en,
    output logic [31:0]      st_addr,
    output logic [31:0]      st_data
);
    localparam int IDEPTH = 1 << IMEM_AW;
    localparam int DDEPTH = 1 << DMEM_AW;

    core_st_t    s_q, s_d;
    logic [31:0] imem_q [IDEPTH];
    logic [31:0] dmem_q [DDEPTH];

    logic [31:0] rf_rd1, rf_rd2, opa_v, opb_v, alu_y;
    logic        alu_zero, ex_we, stall, br_take, jmp_ex;
    logic [31:0] fetch_w, dm_rdata;
    ctl_t        dec;

    // writeback outputs
    always_comb begin
        rf_we    = s_q.memwb.reg_wr && (s_q.memwb.dst != 5'd0);
        rf_waddr = s_q.memwb.dst;
        rf_wdata = s_q.memwb.mem2reg ? s_q.memwb.rdata : s_q.memwb.alu;
        st_en    = s_q.exmem.mem_wr;
        st_addr  = s_q.exmem.alu;
        st_data  = s_q.exmem.rt_val;
        ex_we    = s_q.exmem.reg_wr;
    end

    pipe5_regfile #(.W(32), .N(32)) rf_i (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .ra1(s_q.ifid.instr[25:21]), .ra2(s_q.ifid.instr[20:16]),
        .rd1(rf_rd1), .rd2(rf_rd2)
    );

    pipe5_fwd #(.W(32)) fwd_a_i (
        .clk(clk), .rst_n(rst_n), .src(s_q.idex.rs), .rf_val(s_q.idex.rs_val),
        .ex_we(ex_we), .ex_dst(s_q.exmem.dst), .ex_val(s_q.exmem.alu),
        .wb_we(rf_we), .wb_dst(rf_waddr), .wb_val(rf_wdata), .val(opa_v)
    );

    pipe5_fwd #(.W(32)) fwd_b_i (
        .clk(clk), .rst_n(rst_n), .src(s_q.idex.rt), .rf_val(s_q.idex.rt_val),
        .ex_we(ex_we), .ex_dst(s_q.exmem.dst), .ex_val(s_q.exmem.alu),
        .wb_we(rf_we), .wb_dst(rf_waddr), .wb_val(rf_wdata), .val(opb_v)
    );

    pipe5_alu #(.W(32)) alu_i (
        .a(opa_v), .b(s_q.idex.ctl.alu_src ? s_q.idex.imm : opb_v),
        .mode(s_q.idex.ctl.alu_mode), .funct(s_q.idex.funct),
        .y(alu_y), .zero(alu_zero)
    );

    always_comb begin
        logic [31:0] ins;
        s_d = s_q;

        // memory stage
        dm_rdata = dmem_q[s_q.exmem.alu[DMEM_AW+1:2]];
        br_take  = s_q.exmem.branch && (s_q.exmem.zero ^ s_q.exmem.bne);
        s_d.memwb.mem2reg = s_q.exmem.mem2reg;
        s_d.memwb.reg_wr  = s_q.exmem.reg_wr;
        s_d.memwb.rdata   = dm_rdata;
        s_d.memwb.alu     = s_q.exmem.alu;
        s_d.memwb.dst     = s_q.exmem.dst;

        // execute stage
        jmp_ex = s_q.idex.ctl.jump;
        s_d.exmem.branch  = s_q.idex.ctl.branch;
        s_d.exmem.bne     = s_q.idex.ctl.bne;
        s_d.exmem.mem_rd  = s_q.idex.ctl.mem_rd;
        s_d.exmem.mem_wr  = s_q.idex.ctl.mem_wr;
        s_d.exmem.mem2reg = s_q.idex.ctl.mem2reg;
        s_d.exmem.reg_wr  = s_q.idex.ctl.reg_wr;
        s_d.exmem.bta     = s_q.idex.pc4 + {s_q.idex.imm[29:0], 2'b00};
        s_d.exmem.zero    = alu_zero;
        s_d.exmem.alu     = alu_y;
        s_d.exmem.rt_val  = opb_v;
        s_d.exmem.dst     = s_q.idex.ctl.reg_dst ? s_q.idex.rd : s_q.idex.rt;

        // decode stage
        ins   = s_q.ifid.instr;
        stall = s_q.idex.ctl.mem_rd && (s_q.idex.rt != 5'd0) &&
                ((s_q.idex.rt == ins[25:21]) || (s_q.idex.rt == ins[20:16]));
        dec = '0;
        case (ins[31:26])
            OPC_ALU: begin
                dec.reg_dst  = 1'b1;
                dec.alu_mode = AM_FN;
                dec.reg_wr   = fn_legal(ins[5:0]) && (ins[10:6] == 5'd0);
            end
            OPC_LOAD:  begin dec.alu_src = 1'b1; dec.mem_rd = 1'b1;
                             dec.mem2reg = 1'b1; dec.reg_wr = 1'b1; end
            OPC_STORE: begin dec.alu_src = 1'b1; dec.mem_wr = 1'b1; end
            OPC_BEQ, OPC_BNE: begin
                dec.branch   = 1'b1;
                dec.bne      = (ins[31:26] == OPC_BNE);
                dec.alu_mode = AM_SUB;
            end
            OPC_JUMP: dec.jump = 1'b1;
            default: dec = '0;
        endcase
        if (stall) begin
            s_d.idex = '0;
        end else begin
            s_d.idex.ctl    = dec;
            s_d.idex.pc4    = s_q.ifid.pc4;
            s_d.idex.rs_val = rf_rd1;
            s_d.idex.rt_val = rf_rd2;
            s_d.idex.imm    = {{16{ins[15]}}, ins[15:0]};
            s_d.idex.jtgt   = {s_q.ifid.pc4[31:28], ins[25:0], 2'b00};
            s_d.idex.rs     = ins[25:21];
            s_d.idex.rt     = ins[20:16];
            s_d.idex.rd     = ins[15:11];
            s_d.idex.funct  = ins[5:0];
        end

        // fetch stage and next PC
        fetch_w = imem_q[s_q.pc[IMEM_AW+1:2]];
        if (stall) begin
            if (br_take) begin
                s_d.pend_v = 1'b1;
                s_d.pend_t = s_q.exmem.bta;
            end
        end else begin
            s_d.ifid.instr = fetch_w;
            s_d.ifid.pc4   = s_q.pc + 32'd4;
            s_d.pend_v     = 1'b0;
            if (br_take)       s_d.pc = s_q.exmem.bta;
            else if (jmp_ex)   s_d.pc = s_q.idex.jtgt;
            else if (s_q.pend_v) s_d.pc = s_q.pend_t;
            else               s_d.pc = s_q.pc + 32'd4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem) imem_q[ld_addr[IMEM_AW-1:0]] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem)
            dmem_q[ld_addr[DMEM_AW-1:0]] <= ld_data;
        else if (rst_n && s_q.exmem.mem_wr)
            dmem_q[s_q.exmem.alu[DMEM_AW+1:2]] <= s_q.exmem.rt_val;
    end

    AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (s_q.pc == $past(s_q.pc))); // R6
    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!s_q.idex.ctl.reg_wr && !s_q.idex.ctl.mem_wr && !s_q.idex.ctl.mem_rd)); // R6
    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pc[1:0] == 2'b00)); // R8
    AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take && !stall) |=> (s_q.pc == $past(s_q.exmem.bta))); // R8
    AST_JUMP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_ex && !br_take && !stall) |=> (s_q.pc == $past(s_q.idex.jtgt))); // R9
    AST_NO_WRITE_R0: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != 5'd0)); // R7
endmodule

// File: tb/pipe5_core_tb_top.sv
module pipe5_core_tb_top;
    localparam int IDEPTH = 256;
    localparam int DDEPTH = 64;
    localparam int NCYC   = 140;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        rf_we, st_en;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata, st_addr, st_data;

    always #10 clk = ~clk;

    pipe5_core dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        int          cyc;
        int          kind; // 0 alu, 1 load, 2 store
    } ev_t;

    logic [31:0] prog [IDEPTH];
    logic [31:0] dinit [DDEPTH];
    int          plen;
    string       ptag;
    ev_t         exp_wb[$], exp_st[$], got_wb[$], got_st[$];
    int          n_chk = 0;
    int          n_bad = 0;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int f, int sh = 0);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], f[5:0]};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(int t);
        return {6'h02, t[25:0]};
    endfunction
    function automatic string ktag(int k);
        return (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
    endfunction

    task automatic clear_prog(string tag);
        for (int i = 0; i < IDEPTH; i++) prog[i] = '0;
        for (int i = 0; i < DDEPTH; i++) dinit[i] = $urandom;
        plen = 0;
        ptag = tag;
    endtask
    task automatic emit(logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv, string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %h expected %h", req, ptag, what, act, expv);
        end
    endtask

    // sequential model with delay-slot semantics
    task automatic model_run();
        logic [31:0] rg [32];
        logic [31:0] dm [DDEPTH];
        logic [31:0] pc, nxt, tgt, ins, a, b, r, ea;
        int cd;
        ev_t e;
        exp_wb.delete();
        exp_st.delete();
        for (int i = 0; i < 32; i++) rg[i] = '0;
        for (int i = 0; i < DDEPTH; i++) dm[i] = dinit[i];
        pc = 0; cd = 0; tgt = 0;
        while (pc < plen * 4 || cd > 0) begin
            ins = prog[pc[9:2]];
            nxt = pc + 4;
            a = rg[ins[25:21]];
            b = rg[ins[20:16]];
            ea = a + {{16{ins[15]}}, ins[15:0]};
            if (cd > 0) begin
                cd--;
                if (cd == 0) nxt = tgt;
            end
            case (ins[31:26])
                6'h00: begin
                    bit ok = (ins[10:6] == 0);
                    case (ins[5:0])
                        6'h20: r = a + b;
                        6'h22: r = a - b;
                        6'h24: r = a & b;
                        6'h25: r = a | b;
                        6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                        default: ok = 0;
                    endcase
                    if (ok && ins[15:11] != 0) begin
                        rg[ins[15:11]] = r;
                        e.a = ins[15:11]; e.d = r; e.cyc = 0; e.kind = 0;
                        exp_wb.push_back(e);
                    end
                end
                6'h23: if (ins[20:16] != 0) begin
                    rg[ins[20:16]] = dm[ea[7:2]];
                    e.a = ins[20:16]; e.d = dm[ea[7:2]]; e.cyc = 0; e.kind = 1;
                    exp_wb.push_back(e);
                end
                6'h2B: begin
                    dm[ea[7:2]] = b;
                    e.a = ea; e.d = b; e.cyc = 0; e.kind = 2;
                    exp_st.push_back(e);
                end
                6'h04, 6'h05: if ((a == b) == (ins[31:26] == 6'h04)) begin
                    cd = 3;
                    tgt = pc + 4 + {{14{ins[15]}}, ins[15:0], 2'b00};
                end
                6'h02: begin
                    cd = 2;
                    tgt = {pc[31:28], ins[25:0], 2'b00};
                end
                default: ;
            endcase
            pc = nxt;
        end
    endtask

    task automatic run_prog(bit chk_first);
        ev_t e;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < IDEPTH + DDEPTH; i++) begin
            ld_en   = 1'b1;
            ld_dmem = (i >= IDEPTH);
            ld_addr = (i >= IDEPTH) ? 8'(i - IDEPTH) : 8'(i);
            ld_data = (i >= IDEPTH) ? dinit[i - IDEPTH] : prog[i];
            @(negedge clk);
            if (i == 2) check(!rf_we && !st_en, "R1", {30'd0, rf_we, st_en}, 32'd0, "activity in reset");
        end
        ld_en = 1'b0;
        model_run();
        got_wb.delete();
        got_st.delete();
        rst_n = 1'b1;
        for (int k = 1; k <= NCYC; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (rf_we) begin
                e.a = rf_waddr; e.d = rf_wdata; e.cyc = k; e.kind = 0;
                got_wb.push_back(e);
            end
            if (st_en) begin
                e.a = st_addr; e.d = st_data; e.cyc = k; e.kind = 2;
                got_st.push_back(e);
            end
        end
        check(got_wb.size() == exp_wb.size(), "R2", got_wb.size(), exp_wb.size(), "write count");
        check(got_st.size() == exp_st.size(), "R4", got_st.size(), exp_st.size(), "store count");
        if (chk_first && got_wb.size() > 0)
            check(got_wb[0].cyc == 4, "R1", got_wb[0].cyc, 4, "first write cycle");
        for (int i = 0; i < exp_wb.size() && i < got_wb.size(); i++) begin
            check(got_wb[i].a == exp_wb[i].a, ktag(exp_wb[i].kind), got_wb[i].a, exp_wb[i].a, "dest reg");
            check(got_wb[i].d == exp_wb[i].d, ktag(exp_wb[i].kind), got_wb[i].d, exp_wb[i].d, "write data");
        end
        for (int i = 0; i < exp_st.size() && i < got_st.size(); i++) begin
            check(got_st[i].a == exp_st[i].a, "R4", got_st[i].a, exp_st[i].a, "store addr");
            check(got_st[i].d == exp_st[i].d, "R4", got_st[i].d, exp_st[i].d, "store data");
        end
    endtask

    task automatic gen_random();
        int slots = 0;
        clear_prog("RND");
        for (int i = 0; i < 40; i++) begin
            int sel = $urandom % 10;
            int rs = $urandom % 8, rt = $urandom % 8, rd = $urandom % 8;
            if (slots > 0) begin
                slots--;
                if (sel >= 7) sel = sel % 7;
            end
            if (sel <= 3) begin
                int fsel = $urandom % 6;
                int fn = (fsel == 0) ? 'h20 : (fsel == 1) ? 'h22 : (fsel == 2) ? 'h24 :
                         (fsel == 3) ? 'h25 : (fsel == 4) ? 'h2A : 'h21;
                emit(enc_r(rs, rt, rd, fn));
            end else if (sel <= 5) begin
                emit(enc_i('h23, 0, rt, 4 * ($urandom % DDEPTH)));
            end else if (sel == 6) begin
                emit(enc_i('h2B, 0, rt, 4 * ($urandom % DDEPTH)));
            end else if (i + 4 <= 40) begin
                int t = i + 4 + $urandom % (41 - (i + 4));
                if (sel == 9) begin
                    emit(enc_j(t));
                    slots = 2;
                end else begin
                    emit(enc_i((sel == 7) ? 'h04 : 'h05, rs, rt, t - (i + 1)));
                    slots = 3;
                end
            end else begin
                emit(enc_r(rs, rt, rd, 'h20));
            end
        end
    endtask

    initial begin
        void'($urandom(32'h1BAD5EED));
        repeat (3) @(negedge clk);

        // R1 / R2: every ALU function, signed compare both ways, illegal encodings
        clear_prog("R1");
        dinit[0] = 32'hFFFF_FFF0; dinit[1] = 32'h0000_0007;
        emit(enc_i('h23, 0, 1, 0)); emit(enc_i('h23, 0, 2, 4)); emit(0); emit(0);
        emit(enc_r(1, 2, 3, 'h20)); emit(enc_r(1, 2, 4, 'h22)); emit(enc_r(1, 2, 5, 'h24));
        emit(enc_r(1, 2, 6, 'h25)); emit(enc_r(1, 2, 7, 'h2A)); emit(enc_r(2, 1, 8, 'h2A));
        emit(enc_r(1, 2, 9, 'h21)); emit(enc_r(1, 2, 10, 'h20, 3));
        run_prog(1);

        // R5: forwarding distances and newest-wins
        clear_prog("R5");
        emit(enc_i('h23, 0, 1, 8)); emit(enc_i('h23, 0, 2, 12)); emit(0); emit(0);
        emit(enc_r(1, 2, 3, 'h20)); emit(enc_r(3, 1, 3, 'h20)); emit(enc_r(3, 3, 4, 'h22));
        emit(enc_r(4, 1, 3, 'h22)); emit(enc_r(3, 4, 5, 'h25));
        emit(enc_r(1, 1, 6, 'h20)); emit(enc_r(2, 2, 6, 'h20)); emit(enc_r(6, 0, 7, 'h20));
        emit(enc_i('h2B, 0, 7, 20)); emit(enc_i('h23, 0, 8, 20));
        run_prog(0);

        // R6: load-use pairs, including load feeding a store
        clear_prog("R6");
        emit(enc_i('h23, 0, 1, 16)); emit(enc_r(1, 1, 2, 'h20));
        emit(enc_i('h23, 0, 3, 24)); emit(enc_i('h2B, 0, 3, 28));
        emit(enc_i('h23, 0, 4, 28)); emit(enc_i('h23, 0, 5, 32)); emit(enc_r(5, 4, 6, 'h25));
        emit(enc_i('h23, 0, 7, 36)); emit(enc_i('h23, 7, 8, 0));
        run_prog(0);

        // R7: register zero
        clear_prog("R7");
        emit(enc_i('h23, 0, 1, 4)); emit(enc_r(1, 1, 0, 'h20)); emit(enc_r(0, 1, 2, 'h20));
        emit(enc_i('h23, 0, 0, 8)); emit(enc_r(0, 0, 3, 'h25)); emit(enc_i('h2B, 0, 0, 40));
        run_prog(0);

        // R8: taken and not-taken beq / bne with three slots
        clear_prog("R8");
        dinit[0] = 32'd11; dinit[1] = 32'd22;
        emit(enc_i('h23, 0, 1, 0)); emit(enc_i('h23, 0, 2, 4)); emit(0); emit(0);
        emit(enc_i('h04, 1, 1, 5));
        emit(enc_r(1, 2, 3, 'h20)); emit(enc_r(1, 1, 4, 'h20)); emit(enc_r(2, 1, 5, 'h22));
        emit(enc_r(1, 1, 6, 'h20)); emit(enc_r(1, 1, 7, 'h20));
        emit(enc_i('h05, 1, 1, 9));
        emit(enc_r(1, 2, 8, 'h25)); emit(enc_r(1, 2, 9, 'h24)); emit(enc_r(2, 2, 10, 'h20));
        emit(enc_i('h04, 1, 2, 5));
        emit(enc_r(1, 1, 11, 'h20)); emit(enc_r(2, 2, 11, 'h20)); emit(enc_r(11, 1, 12, 'h20));
        emit(enc_i('h05, 1, 2, 5));
        emit(enc_r(1, 2, 13, 'h20)); emit(enc_r(1, 2, 14, 'h22)); emit(enc_r(2, 1, 15, 'h22));
        emit(enc_r(1, 1, 16, 'h20)); emit(enc_r(1, 1, 17, 'h20));
        emit(enc_r(2, 2, 18, 'h20));
        run_prog(0);

        // R9: jumps with two slots, one slot pair being a load-use
        clear_prog("R9");
        emit(enc_i('h23, 0, 1, 0)); emit(0); emit(0); emit(enc_j(8));
        emit(enc_r(1, 1, 2, 'h20)); emit(enc_r(2, 1, 3, 'h20));
        emit(enc_r(1, 1, 4, 'h20)); emit(enc_r(1, 1, 5, 'h20));
        emit(enc_r(3, 1, 6, 'h20)); emit(enc_j(14));
        emit(enc_i('h23, 0, 7, 4)); emit(enc_r(7, 7, 8, 'h20));
        emit(enc_r(1, 1, 9, 'h20)); emit(enc_r(1, 1, 10, 'h20));
        emit(enc_r(8, 1, 11, 'h20));
        run_prog(0);

        // R10: register-file pass-through at distance three
        clear_prog("R10");
        emit(enc_i('h23, 0, 1, 0)); emit(0); emit(0); emit(0);
        emit(enc_r(1, 1, 2, 'h20)); emit(enc_r(2, 2, 3, 'h20)); emit(0); emit(0);
        emit(enc_r(3, 2, 4, 'h22)); emit(0); emit(0); emit(enc_r(4, 4, 5, 'h25));
        run_prog(0);

        for (int n = 0; n < 8; n++) begin
            gen_random();
            run_prog(0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule